// File: doc/BRIEF.md
# Refresh Scheduler with CAS-Before-RAS Sequencing

This block keeps a DRAM's contents alive by asking for refresh slots at a steady rate and then running the refresh strobe pattern itself. It never drives a row address, because the memory's own internal counter picks the row whenever CAS is already low when RAS falls. A free-running interval timer adds one owed refresh to a small pending count. While anything is owed and the sequencer is idle, the block raises a request towards the access controller. The controller answers with a grant once the bus is idle. Each accepted grant runs one refresh and removes one owed refresh from the count.

Refreshes may be postponed while the controller is busy, and up to a fixed number can build up. These are then worked off back to back once grants come. When the pending count reaches its ceiling, an urgent flag tells the controller that it must grant at once, or a row would pass its retention window. A parameter chooses the interval: one refresh per 15.6 us for the standard part, or one per 62.5 us for the low-power part.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During reset and right after it, RAS, CAS and WE are high, and request, urgent, done and bus-ownership are all low.
- R2: The pending count gains one owed refresh on every REFI-th rising clock edge after reset is released. REFI is REFI_STD_CYC when LOW_POWER=0 and REFI_LP_CYC otherwise. With no grant given, the request first shows after the REFI-th edge.
- R3: ref_req_o is high exactly when the pending count is nonzero and the sequencer is idle. It is low while the sequence runs and during its done cycle.
- R4: The pending count saturates at MAX_PEND. ref_urgent_o is high exactly when the count equals MAX_PEND.
- R5: A grant is accepted only at a clock edge where ref_req_o is also high. A grant at any other time has no effect on the strobes or on the count. An accepted grant lowers the count by one, and bus_own_o rises in the next cycle.
- R6: After acceptance, bus_own_o is high and the strobes run in this order. First both strobes stay high for T_CRP cycles. Then CAS is low with RAS high for T_CSR cycles. Then both are low for T_RAS cycles. Last, both are high for T_RP cycles.
- R7: we_n_o stays high at all times.
- R8: ref_done_o is a single-cycle pulse in the cycle after the precharge phase. In that cycle bus_own_o is low and both strobes are high.
- R9: If an increment from the timer and an accepted grant fall on the same edge, the count is unchanged. This holds even at MAX_PEND, so urgent stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Grant from the access controller |
| ref_req_o | output | 1 | Refresh request |
| ref_urgent_o | output | 1 | Pending count is at its ceiling |
| ref_done_o | output | 1 | One-cycle pulse when a refresh has completed, including its precharge |
| bus_own_o | output | 1 | Scheduler drives the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The count changes on the edge after the timer's last cycle, so the request rises one cycle after the REFI-th edge and is sampled at the falling edge that follows. A grant sampled at edge k makes bus_own_o high in the cycle after k. The strobe phases follow in their fixed order, and the done pulse comes T_CRP+T_CSR+T_RAS+T_RP cycles after that first owned cycle. The bench keeps its own edge counter and its own pending count. On each acceptance it queues the expected per-cycle strobe pattern, and at every falling edge it compares the outputs with the head of that queue.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CRP,
    ST_CSR,
    ST_RASL,
    ST_PRE,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobes_t;
endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int unsigned REFI_CYC = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pend_ctr.sv
module pend_ctr #(
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic full_o
);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW:0]   sum;

  // simultaneous tick and decrement cancel, even at the ceiling
  always_comb begin
    sum = {1'b0, cnt_q} + {{PW{1'b0}}, tick_i} - {{PW{1'b0}}, dec_i};
    if (sum > (PW+1)'(MAX_PEND)) cnt_d = PW'(MAX_PEND);
    else                         cnt_d = sum[PW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign nonzero_o = (cnt_q != '0);
  assign full_o    = (cnt_q == PW'(MAX_PEND));
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned T_CRP = 1,
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 3,
  parameter int unsigned T_RP  = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  output strobes_t strb_o,
  output logic     own_o,
  output logic     done_o,
  output logic     idle_o
);
  localparam int unsigned TM1  = (T_CRP > T_CSR) ? T_CRP : T_CSR;
  localparam int unsigned TM2  = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int unsigned TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CRP;
          cnt_q   <= CW'(T_CRP - 1);
        end
        ST_CRP: if (last) begin
          state_q <= ST_CSR;
          cnt_q   <= CW'(T_CSR - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_CSR: if (last) begin
          state_q <= ST_RASL;
          cnt_q   <= CW'(T_RAS - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_RASL: if (last) begin
          state_q <= ST_PRE;
          cnt_q   <= CW'(T_RP - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_PRE: if (last) state_q <= ST_DONE;
        else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // CAS falls one phase ahead of RAS so the part takes its own row address
  always_comb begin
    strb_o.ras_n = (state_q != ST_RASL);
    strb_o.cas_n = !(state_q inside {ST_CSR, ST_RASL});
    strb_o.we_n  = 1'b1;
  end

  assign own_o  = state_q inside {ST_CRP, ST_CSR, ST_RASL, ST_PRE};
  assign done_o = (state_q == ST_DONE);
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter bit          LOW_POWER    = 1'b0,
  parameter int unsigned REFI_STD_CYC = 780,
  parameter int unsigned REFI_LP_CYC  = 3125,
  parameter int unsigned MAX_PEND     = 8,
  parameter int unsigned T_CRP        = 1,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = 3,
  parameter int unsigned T_RP         = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ref_done_o,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int unsigned REFI_CYC = LOW_POWER ? REFI_LP_CYC : REFI_STD_CYC;

  logic     tick, owed, idle, accept;
  strobes_t strb;

  refi_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .dec_i    (accept),
    .nonzero_o(owed),
    .full_o   (ref_urgent_o)
  );

  cbr_seq #(
    .T_CRP(T_CRP), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .strb_o (strb),
    .own_o  (bus_own_o),
    .done_o (ref_done_o),
    .idle_o (idle)
  );

  assign ref_req_o = owed && idle;
  assign accept    = ref_req_o && ref_gnt_i;
  assign ras_n_o   = strb.ras_n;
  assign cas_n_o   = strb.cas_n;
  assign we_n_o    = strb.we_n;
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
  parameter int unsigned T_RAS = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_gnt_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic ref_done_o,
  input logic bus_own_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o
);
  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ras_lo_cnt <= '0;
    else if (ras_n_o)                ras_lo_cnt <= '0;
    else if (ras_lo_cnt != 16'hffff) ras_lo_cnt <= ras_lo_cnt + 1'b1;
  end

  a_r6_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));

  a_r6_ras_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (32'(ras_lo_cnt) >= T_RAS));

  a_r3_no_req_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_own_o || ref_done_o) |-> !ref_req_o);

  a_r4_urgent_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_urgent_o && !bus_own_o && !ref_done_o) |-> ref_req_o);

  a_r5_grant_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i) |=> bus_own_o);

  a_r8_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |-> (ras_n_o && cas_n_o && we_n_o && !bus_own_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);
endmodule

bind cbr_refresh_sched cbr_refresh_chk #(.T_RAS(T_RAS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_gnt_i   (ref_gnt_i),
  .ref_req_o   (ref_req_o),
  .ref_urgent_o(ref_urgent_o),
  .ref_done_o  (ref_done_o),
  .bus_own_o   (bus_own_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o)
);

// File: tb/cbr_refresh_sched_tb.sv
module cbr_refresh_sched_tb;
  localparam int REFI  = 16;
  localparam int MAXP  = 8;
  localparam int T_CRP = 1, T_CSR = 1, T_RAS = 3, T_RP = 2;

  typedef struct packed { bit ras, cas, we, own, done; } exp_t;
  localparam exp_t IDLE_V = '{ras: 1, cas: 1, we: 1, own: 0, done: 0};

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic req, urgent, done, own, ras_n, cas_n, we_n;

  int checks = 0, failures = 0;
  int edge_n = 0, pend = 0;
  bit exp_req = 0, exp_urgent = 0, last_accept = 0;
  exp_t cur = IDLE_V;
  exp_t q[$];

  always #10 clk = ~clk;

  cbr_refresh_sched #(
    .REFI_STD_CYC(REFI), .MAX_PEND(MAXP),
    .T_CRP(T_CRP), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt),
    .ref_req_o(req), .ref_urgent_o(urgent), .ref_done_o(done),
    .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", r, edge_n, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected per-cycle strobes of one refresh (R6, R8)
  task automatic push_seq();
    for (int i = 0; i < T_CRP; i++) q.push_back('{ras: 1, cas: 1, we: 1, own: 1, done: 0});
    for (int i = 0; i < T_CSR; i++) q.push_back('{ras: 1, cas: 0, we: 1, own: 1, done: 0});
    for (int i = 0; i < T_RAS; i++) q.push_back('{ras: 0, cas: 0, we: 1, own: 1, done: 0});
    for (int i = 0; i < T_RP;  i++) q.push_back('{ras: 1, cas: 1, we: 1, own: 1, done: 0});
    q.push_back('{ras: 1, cas: 1, we: 1, own: 0, done: 1});
  endtask

  // reference model, from the requirements
  always @(posedge clk) if (rst_n) begin
    bit acc, tick;
    int n;
    edge_n++;
    acc  = gnt && exp_req;                   // R5
    tick = (edge_n % REFI == 0);             // R2
    if (q.size() != 0) cur = q.pop_front(); else cur = IDLE_V;
    if (acc) begin push_seq(); cur = q.pop_front(); end
    n = pend + int'(tick) - int'(acc);       // R9
    if (n > MAXP) n = MAXP;                  // R4
    pend        = n;
    exp_urgent  = (pend == MAXP);
    exp_req     = (pend != 0) && !(cur.own || cur.done);  // R3
    last_accept = acc;
  end

  // monitor
  always @(negedge clk) if (rst_n && edge_n > 0) begin
    chk("R6 ras_n", ras_n, cur.ras);
    chk("R6 cas_n", cas_n, cur.cas);
    chk("R7 we_n", we_n, 1'b1);
    chk("R6 bus_own", own, cur.own);
    chk("R8 done", done, cur.done);
    chk("R3 req", req, exp_req);
    chk("R4 urgent", urgent, exp_urgent);
    if (last_accept) chk("R5 own after grant", own, 1'b1);
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
        chk("R1 req", req, 0); chk("R1 urgent", urgent, 0);
        chk("R1 done", done, 0); chk("R1 own", own, 0);
        rst_n = 1'b1;
        // R2: first request after the REFI-th edge
        while (edge_n != REFI - 1) @(negedge clk);
        chk("R2 req before interval", req, 0);
        @(negedge clk);
        chk("R2 req after interval", req, 1);
        // R4: saturate
        repeat (9 * REFI) @(negedge clk);
        chk("R4 urgent at ceiling", urgent, 1);
        // single grant, then a grant while busy (ignored, R5)
        gnt = 1'b1; @(negedge clk); gnt = 1'b0;
        repeat (3) @(negedge clk);
        gnt = 1'b1; @(negedge clk); gnt = 1'b0;
        repeat (3 * REFI) @(negedge clk);
        // R9: grant on the same edge as a timer increment at the ceiling
        while (!(((edge_n + 1) % REFI == 0) && req && urgent)) @(negedge clk);
        gnt = 1'b1; @(negedge clk); gnt = 1'b0;
        chk("R9 urgent kept", urgent, 1);
        chk("R9 own", own, 1);
        repeat (20) @(negedge clk);
        // back-to-back draining with grant held
        gnt = 1'b1;
        repeat (200) @(negedge clk);
        gnt = 1'b0;
        // pseudo-random grants, many while req is low
        begin
          logic [7:0] lfsr = 8'h5a;
          for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            gnt = lfsr[0] & lfsr[3];
            @(negedge clk);
          end
        end
        gnt = 1'b0;
        repeat (10) @(negedge clk);
      end
      begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule